// File: doc/BRIEF.md
# Watchdog Timer With Sticky Enable

This block is a supervision counter. Once software arms it, the counter advances by one on every clock. Software has to restart the counter, by kicking it, before the count reaches a programmable limit. If no kick arrives in time, the block raises a one-cycle reset request toward the chip's reset controller.

Arming works only in one direction. Software can set the arm bit but can never clear it. Only the power-on reset returns the block to the disarmed state. Any other system reset, including the one this block requests, clears the count and leaves the arm bit set, so supervision carries on after the reset.

Software uses one write port. A two-bit selector picks the target: 0 is the control word, 1 is the limit, 2 is the kick, and 3 is unused. The arm state, the running count and the stored limit are visible on outputs.

Top module: `wdog_top`

## Requirements
- R1: While `porN` is low at a clock edge, the block clears the arm bit, the count and `rstReq`, and loads the limit with the `DEF_LIMIT` parameter.
- R2: A write with selector 0 and data bit 0 equal to 1 sets `armed` at that clock edge.
- R3: Once `armed` is set, nothing except `porN` low clears it. This includes selector-0 writes with data bit 0 equal to 0.
- R4: While `sysRstN` is low at an edge, the count goes to 0 and `rstReq` goes low. The arm bit and the limit keep their values.
- R5: While disarmed, the count stays at 0 and `rstReq` stays low, whatever writes and kicks arrive.
- R6: While armed, with no kick and a count below the limit, the count rises by exactly 1 per clock.
- R7: A write with selector 2 (kick) while armed sets the count to 0 at that edge and suppresses `rstReq`, even when the count has reached the limit.
- R8: While armed and not kicked, an edge at which the count is at or above the limit sets the count to 0 and drives `rstReq` high for exactly one cycle.
- R9: A write with selector 1 loads the limit from the write data, and a data value of 0 is stored as 1. The new limit applies from the next comparison onward.
- R10: A write with selector 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, synchronous |
| sysRstN | input | 1 | Any other system reset, active low, synchronous |
| regWr | input | 1 | Write strobe |
| regSel | input | 2 | Write target: 0 control, 1 limit, 2 kick, 3 unused |
| regData | input | CNT_W | Write data; bit 0 is the arm bit for selector 0 |
| rstReq | output | 1 | One-cycle reset request |
| armed | output | 1 | Arm bit read-back |
| count | output | CNT_W | Current count |
| limit | output | CNT_W | Stored limit |

## Verification
The bench builds the block with an 8-bit counter and a default limit of 5. With these values, the limit can be set to 3 and then to 1, so an expiry, a kick that lands exactly on the limit and back-to-back expiries all happen within a few dozen cycles. Lowering the limit below a count that is already running shows that expiry is an at-or-above comparison. A later long run with a limit of 200 confirms that the count advances cleanly over many cycles without wrapping.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_KICK  = 2'd2,
    SEL_SPARE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic cntClr;
    logic cntStep;
    logic limLoad;
  } dpStrobe_t;

endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DEF_LIMIT = 1000
) (
  input  logic             clk,
  input  logic             porN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             expired
);

  // A zero limit would request reset on every cycle; clamp to one.
  localparam logic [CNT_W-1:0] LIM_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] LIM_RESET =
    (DEF_LIMIT == 0) ? LIM_ONE : CNT_W'(DEF_LIMIT);

  logic [CNT_W-1:0] limNext;

  always_comb begin
    limNext = (wrData == '0) ? LIM_ONE : wrData;
  end

  always_ff @(posedge clk) begin
    if (!porN) begin
      limit <= LIM_RESET;
    end else if (strobe.limLoad) begin
      limit <= limNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!porN || strobe.cntClr) begin
      count <= '0;
    end else if (strobe.cntStep) begin
      count <= count + LIM_ONE;
    end
  end

  always_comb begin
    expired = (count >= limit);
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      porN,
  input  logic      sysRstN,
  input  logic      regWr,
  input  logic [1:0] regSel,
  input  logic      enBit,
  input  logic      expired,
  output dpStrobe_t strobe,
  output logic      armed,
  output logic      rstReq
);

  regSel_e selDec;
  logic    kick;
  logic    armSet;

  always_comb begin
    selDec = regSel_e'(regSel);
    kick   = regWr && (selDec == SEL_KICK);
    armSet = regWr && (selDec == SEL_CTRL) && enBit;
  end

  // Set-only arm bit: software has no path to clear it.
  always_ff @(posedge clk) begin
    if (!porN) begin
      armed <= 1'b0;
    end else if (armSet) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    strobe.limLoad = regWr && (selDec == SEL_LIMIT);
    strobe.cntClr  = !armed || !sysRstN || kick || expired;
    strobe.cntStep = !strobe.cntClr;
  end

  always_ff @(posedge clk) begin
    if (!porN || !sysRstN) begin
      rstReq <= 1'b0;
    end else begin
      rstReq <= armed && !kick && expired;
    end
  end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DEF_LIMIT = 1000
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             sysRstN,
  input  logic             regWr,
  input  logic [1:0]       regSel,
  input  logic [CNT_W-1:0] regData,
  output logic             rstReq,
  output logic             armed,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit
);

  dpStrobe_t strobe;
  logic      expired;

  wdog_ctrl u_ctrl (
    .clk     (clk),
    .porN    (porN),
    .sysRstN (sysRstN),
    .regWr   (regWr),
    .regSel  (regSel),
    .enBit   (regData[0]),
    .expired (expired),
    .strobe  (strobe),
    .armed   (armed),
    .rstReq  (rstReq)
  );

  wdog_dp #(
    .CNT_W     (CNT_W),
    .DEF_LIMIT (DEF_LIMIT)
  ) u_dp (
    .clk     (clk),
    .porN    (porN),
    .strobe  (strobe),
    .wrData  (regData),
    .count   (count),
    .limit   (limit),
    .expired (expired)
  );

endmodule

// File: rtl/wdog_props.sv
module wdog_props #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             porN,
  input logic             sysRstN,
  input logic             regWr,
  input logic [1:0]       regSel,
  input logic             rstReq,
  input logic             armed,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] limit
);

  logic kickWr;
  assign kickWr = regWr && (regSel == 2'd2);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!porN)
    armed |=> armed);

  p_idle_r5: assert property (@(posedge clk) disable iff (!porN)
    !armed |-> (count == '0) && !rstReq);

  p_sysrst_r4: assert property (@(posedge clk) disable iff (!porN)
    !sysRstN |=> (count == '0) && !rstReq);

  p_step_r6: assert property (@(posedge clk) disable iff (!porN)
    armed && sysRstN && !kickWr && (count < limit)
      |=> count == CNT_W'($past(count) + 1'b1));

  p_kick_r7: assert property (@(posedge clk) disable iff (!porN)
    armed && sysRstN && kickWr |=> (count == '0) && !rstReq);

  p_expire_r8: assert property (@(posedge clk) disable iff (!porN)
    armed && sysRstN && !kickWr && (count >= limit)
      |=> rstReq && (count == '0));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!porN)
    rstReq |=> !rstReq);

  p_limit_nonzero_r9: assert property (@(posedge clk) disable iff (!porN)
    limit != '0);

endmodule

bind wdog_top wdog_props #(.CNT_W(CNT_W)) u_props (
  .clk     (clk),
  .porN    (porN),
  .sysRstN (sysRstN),
  .regWr   (regWr),
  .regSel  (regSel),
  .rstReq  (rstReq),
  .armed   (armed),
  .count   (count),
  .limit   (limit)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;

  localparam int CW = 8;
  localparam int DL = 5;

  logic          clk = 1'b0;
  logic          porN = 1'b0;
  logic          sysRstN = 1'b1;
  logic          regWr = 1'b0;
  logic [1:0]    regSel = 2'd0;
  logic [CW-1:0] regData = '0;
  logic          rstReq;
  logic          armed;
  logic [CW-1:0] count;
  logic [CW-1:0] limit;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wdog_top #(.CNT_W(CW), .DEF_LIMIT(DL)) u0 (
    .clk(clk), .porN(porN), .sysRstN(sysRstN), .regWr(regWr),
    .regSel(regSel), .regData(regData), .rstReq(rstReq),
    .armed(armed), .count(count), .limit(limit)
  );

  typedef struct packed {
    logic          wr;
    logic [1:0]    sel;
    logic [CW-1:0] data;
    logic          srN;
    logic          eArm;
    logic [CW-1:0] eCnt;
    logic          eReq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{1'b1, 2'd0, 8'd0, 1'b1, 1'b0, 8'd0, 1'b0},
    '{1'b1, 2'd2, 8'd0, 1'b1, 1'b0, 8'd0, 1'b0},
    '{1'b1, 2'd1, 8'd3, 1'b1, 1'b0, 8'd0, 1'b0},
    '{1'b1, 2'd0, 8'd1, 1'b1, 1'b1, 8'd0, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd1, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd2, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd3, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd0, 1'b1},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd1, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd2, 1'b0},
    '{1'b1, 2'd2, 8'd0, 1'b1, 1'b1, 8'd0, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd1, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd2, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd3, 1'b0},
    '{1'b1, 2'd2, 8'd0, 1'b1, 1'b1, 8'd0, 1'b0},
    '{1'b1, 2'd0, 8'd0, 1'b1, 1'b1, 8'd1, 1'b0},
    '{1'b1, 2'd3, 8'd0, 1'b1, 1'b1, 8'd2, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b0, 1'b1, 8'd0, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd1, 1'b0},
    '{1'b1, 2'd1, 8'd0, 1'b1, 1'b1, 8'd2, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd0, 1'b1},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd1, 1'b0},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd0, 1'b1},
    '{1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 8'd1, 1'b0}
  };

  function automatic string tagOf(int i);
    case (i)
      0, 1, 2:     return "R5";
      3:           return "R2";
      4, 5, 6:     return "R6";
      7, 8, 9:     return "R8";
      10, 14:      return "R7";
      15:          return "R3";
      16:          return "R10";
      17:          return "R4";
      19, 20, 22:  return "R9";
      default:     return "R6";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkState(string tag, logic eArm, logic [CW-1:0] eCnt, logic eReq);
    nChecks++;
    if (armed !== eArm || count !== eCnt || rstReq !== eReq) begin
      nFails++;
      $display("FAIL %s: actual arm=%0d cnt=%0d req=%0d expected arm=%0d cnt=%0d req=%0d",
               tag, armed, count, rstReq, eArm, eCnt, eReq);
    end
  endtask

  task automatic step(logic wr, logic [1:0] sel, logic [CW-1:0] data, logic srN);
    @(negedge clk);
    regWr = wr; regSel = sel; regData = data; sysRstN = srN;
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    // R1: power-on state
    step(1'b0, 2'd0, '0, 1'b1);
    step(1'b1, 2'd0, 8'd1, 1'b1);
    chkState("R1", 1'b0, 8'd0, 1'b0);
    chk("R1 limit", 32'(limit), DL);
    @(negedge clk); porN = 1'b1; regWr = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VT[i].wr, VT[i].sel, VT[i].data, VT[i].srN);
      chkState(tagOf(i), VT[i].eArm, VT[i].eCnt, VT[i].eReq);
    end
    step(1'b0, 2'd0, '0, 1'b1);
    chk("R9 zero clamps to one", 32'(limit), 1);

    // R10: spare selector leaves the limit alone
    step(1'b1, 2'd3, 8'd77, 1'b1);
    chk("R10 limit", 32'(limit), 1);

    // R1: power-on clears a set arm bit and restores the limit
    @(negedge clk); porN = 1'b0; regWr = 1'b0;
    @(posedge clk); #1;
    chkState("R1 re-por", 1'b0, 8'd0, 1'b0);
    chk("R1 re-por limit", 32'(limit), DL);
    @(negedge clk); porN = 1'b1;

    // R5: kicks and limit writes while disarmed
    step(1'b1, 2'd1, 8'd1, 1'b1);
    for (int k = 0; k < 6; k++) begin
      step(k[0], 2'd2, '0, 1'b1);
      chkState("R5 idle", 1'b0, 8'd0, 1'b0);
    end

    // R6: long run below a large limit
    step(1'b1, 2'd1, 8'd200, 1'b1);
    step(1'b1, 2'd0, 8'd1, 1'b1);
    chkState("R2 rearm", 1'b1, 8'd0, 1'b0);
    for (int k = 1; k <= 150; k++) begin
      step(1'b0, 2'd0, '0, 1'b1);
      chkState("R6 run", 1'b1, CW'(k), 1'b0);
    end

    // R4: system reset keeps arm and limit
    step(1'b0, 2'd0, '0, 1'b0);
    chkState("R4 sysrst", 1'b1, 8'd0, 1'b0);
    chk("R4 limit kept", 32'(limit), 200);

    finishRun();
  end

endmodule